// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit carries out the multiply and divide group of a 32-bit integer pipeline. The issuing stage presents a full instruction word, a request strobe and the two source operand values. The unit decodes the word itself. If the word belongs to the multiply/divide group and the unit is idle, the unit accepts it and latches the operands.

Multiplies take one cycle in a single-cycle array multiplier. Divides and remainders use a restoring divider that retires one quotient bit per clock. A sign-fix stage follows the divider. While an operation is in flight, the unit raises `busy`, and the surrounding pipeline holds its issue stage on that signal. Completion is marked by a one-cycle `done` pulse. The registered `result` holds its value until the next completion.

Top module: `mdu_top`

## Requirements
- R1: A request is taken only when `insn[6:0]` = 7'b0110011 and `insn[31:25]` = 7'b0000001. Any other word is ignored: no `done`, `busy` stays low and `result` is unchanged.
- R2: `insn[14:12]` picks the operation. The codes are 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM and 7 REMU.
- R3: MUL returns the low 32 bits of the product.
- R4: MULH, MULHSU and MULHU return the upper 32 bits of the 64-bit product. MULH treats both operands as signed. MULHSU treats `src_a` as signed and `src_b` as unsigned. MULHU treats both as unsigned.
- R5: Division truncates toward zero. A signed quotient is negative when exactly one operand is negative. A signed remainder takes the sign of the dividend. DIVU and REMU treat both operands as unsigned.
- R6: Dividing by zero gives a quotient of 32'hFFFFFFFF and a remainder equal to the dividend.
- R7: 32'h80000000 divided by 32'hFFFFFFFF (signed) gives a quotient of 32'h80000000 and a remainder of 0.
- R8: For a multiply accepted at clock edge N, `busy` is high between edges N and N+1, and `done` is high after edge N+1.
- R9: For a divide or remainder accepted at edge N, `busy` stays high until edge N+33. `done` rises after edge N+33, which is the same edge at which `busy` falls.
- R10: A request presented while `busy` is high is ignored. Changes on `src_a`, `src_b` or `insn` after acceptance do not alter the result of the operation in flight.
- R11: After a synchronous reset, `busy` and `done` are low and `result` is 0.
- R12: `done` lasts exactly one cycle. `result` changes only in a cycle where `done` is high, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for `insn` and the operands |
| insn | input | 32 | Instruction word to decode |
| src_a | input | 32 | First source operand (dividend or multiplicand) |
| src_b | input | 32 | Second source operand (divisor or multiplier) |
| busy | output | 1 | An operation is in flight; the issue stage must stall |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Registered result, valid from `done` onward |

## Verification
Two events can coincide in one cycle: the completion pulse of one operation and the acceptance of the next. With `busy` already low, the bench presents the next request in the same cycle that `done` is high. It then checks three things: the earlier result is intact, the new operation keeps its own latency, and `done` drops at the edge that takes the new request. A second overlap comes from requests that arrive while a divide is still running. These must neither start work nor add an extra pulse. The bench judges this from the divide's own result and from the cycle in which `done` appears.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_FIX
  } mdu_state_e;

  localparam logic [6:0] OPC_REG_ARITH = 7'b0110011;
  localparam logic [6:0] F7_MULDIV     = 7'b0000001;

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit,
  output mdu_op_e     op,
  output logic        is_div,
  output logic        sgn_a,
  output logic        sgn_b
);

  logic unused_fields;
  assign unused_fields = ^{insn[24:15], insn[11:7]};

  always_comb begin
    hit    = (insn[6:0] == OPC_REG_ARITH) && (insn[31:25] == F7_MULDIV);
    op     = mdu_op_e'(insn[14:12]);
    is_div = insn[14];
    unique case (op)
      OP_MULH:        begin sgn_a = 1'b1; sgn_b = 1'b1; end
      OP_MULHSU:      begin sgn_a = 1'b1; sgn_b = 1'b0; end
      OP_DIV, OP_REM: begin sgn_a = 1'b1; sgn_b = 1'b1; end
      default:        begin sgn_a = 1'b0; sgn_b = 1'b0; end
    endcase
  end

endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sgn_a,
  input  logic            sgn_b,
  input  logic            upper,
  output logic [XLEN-1:0] prod
);

  localparam int PW = 2 * XLEN;

  logic [PW-1:0] ext_a, ext_b, full;

  // Sign extension to the full product width keeps the product exact modulo 2^PW
  assign ext_a = {{XLEN{sgn_a & a[XLEN-1]}}, a};
  assign ext_b = {{XLEN{sgn_b & b[XLEN-1]}}, b};
  assign full  = ext_a * ext_b;
  assign prod  = upper ? full[PW-1:XLEN] : full[XLEN-1:0];

endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] dvd,
  input  logic [XLEN-1:0] dvs,
  output logic            last,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);

  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

  logic            run_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] q_q, r_q, d_q;
  logic [XLEN:0]   shifted, trial;

  assign shifted = {r_q, q_q[XLEN-1]};
  assign trial   = shifted - {1'b0, d_q};
  assign last    = run_q && (cnt_q == LAST_STEP);
  assign quo     = q_q;
  assign rem     = r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      q_q   <= dvd;
      r_q   <= '0;
      d_q   <= dvs;
    end else if (run_q) begin
      r_q   <= trial[XLEN] ? shifted[XLEN-1:0] : trial[XLEN-1:0];
      q_q   <= {q_q[XLEN-2:0], ~trial[XLEN]};
      cnt_q <= cnt_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end

  AST_PARTIAL_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (run_q && d_q != '0) |-> (r_q < d_q)); // R5

  AST_START_ONLY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q); // R10

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);

  localparam int MSB = XLEN - 1;
  localparam int LW  = $clog2(XLEN + 2) + 1;

  mdu_state_e      state_q;
  mdu_op_e         dec_op, op_q;
  logic            dec_hit, dec_div, dec_sa, dec_sb;
  logic            sa_q, sb_q;
  logic [XLEN-1:0] a_q, b_q;
  logic [XLEN-1:0] mag_a, mag_b, mul_res, div_quo, div_rem;
  logic [XLEN-1:0] q_fix, r_fix;
  logic            accept, div_start, div_last;

  mdu_decode u_dec (
    .insn   (insn),
    .hit    (dec_hit),
    .op     (dec_op),
    .is_div (dec_div),
    .sgn_a  (dec_sa),
    .sgn_b  (dec_sb)
  );

  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && dec_hit && !busy;
  assign div_start = accept && dec_div;
  assign mag_a     = (dec_sa && src_a[MSB]) ? -src_a : src_a;
  assign mag_b     = (dec_sb && src_b[MSB]) ? -src_b : src_b;

  mdu_mul #(.XLEN(XLEN)) u_mul (
    .a     (a_q),
    .b     (b_q),
    .sgn_a (sa_q),
    .sgn_b (sb_q),
    .upper (op_q != OP_MUL),
    .prod  (mul_res)
  );

  mdu_div #(.XLEN(XLEN)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .dvd   (mag_a),
    .dvs   (mag_b),
    .last  (div_last),
    .quo   (div_quo),
    .rem   (div_rem)
  );

  // Sign correction after the magnitude divide
  always_comb begin
    if (b_q == '0)
      q_fix = '1;
    else if (sa_q && (a_q[MSB] ^ b_q[MSB]))
      q_fix = -div_quo;
    else
      q_fix = div_quo;
    r_fix = (sa_q && a_q[MSB]) ? -div_rem : div_rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_MUL;
      a_q     <= '0;
      b_q     <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= dec_op;
          a_q     <= src_a;
          b_q     <= src_b;
          sa_q    <= dec_sa;
          sb_q    <= dec_sb;
          state_q <= dec_div ? ST_DIV : ST_MUL;
        end
        ST_MUL: begin
          result  <= mul_res;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_DIV: if (div_last) state_q <= ST_FIX;
        ST_FIX: begin
          result  <= op_q[1] ? r_fix : q_fix;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Cycles since acceptance, kept for the latency check only
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (busy)   lat_q <= lat_q + 1'b1;
  end

  AST_FOREIGN_WORD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !dec_hit) |=> (!busy && !done)); // R1

  AST_MUL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec_div) |=> (busy ##1 (done && !busy))); // R8

  AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (done && op_q[2]) |-> (lat_q == LW'(XLEN + 1))); // R9

  AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q) && $stable(op_q))); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R12

endmodule

// File: tb/test_mdu_top.sv
module test_mdu_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mdu_top #(.XLEN(32)) i_mdu_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b), .busy(busy), .done(done), .result(result)
  );

  // Rows: {funct3, a, b, expected}
  localparam int NV = 20;
  localparam logic [98:0] VEC [NV] = '{
    {3'd0, 32'h00000007, 32'h00000006, 32'h0000002A},  // R3
    {3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001},  // R3
    {3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},  // R4
    {3'd1, 32'h80000000, 32'h80000000, 32'h40000000},  // R4
    {3'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h3FFFFFFF},  // R4
    {3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R4
    {3'd2, 32'h80000000, 32'h00000002, 32'hFFFFFFFF},  // R4
    {3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},  // R4
    {3'd4, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD},  // R5
    {3'd6, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF},  // R5
    {3'd4, 32'h00000007, 32'hFFFFFFFE, 32'hFFFFFFFD},  // R5
    {3'd6, 32'h00000007, 32'hFFFFFFFE, 32'h00000001},  // R5
    {3'd5, 32'hFFFFFFFF, 32'h00000002, 32'h7FFFFFFF},  // R5
    {3'd7, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},  // R5
    {3'd4, 32'hFFFFFFFB, 32'h00000000, 32'hFFFFFFFF},  // R6
    {3'd6, 32'hFFFFFFFB, 32'h00000000, 32'hFFFFFFFB},  // R6
    {3'd5, 32'h80000000, 32'h00000000, 32'hFFFFFFFF},  // R6
    {3'd7, 32'h00001234, 32'h00000000, 32'h00001234},  // R6
    {3'd4, 32'h80000000, 32'hFFFFFFFF, 32'h80000000},  // R7
    {3'd6, 32'h80000000, 32'hFFFFFFFF, 32'h00000000}   // R7
  };

  function automatic logic [31:0] mk_insn(input logic [2:0] f3);
    return {7'b0000001, 5'd12, 5'd11, f3, 5'd10, 7'b0110011};
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    if (f == 3'd0) return "R3";
    if (f <= 3'd3) return "R4";
    if (b == 32'd0) return "R6";
    if (!f[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R7";
    return "R5";
  endfunction

  function automatic logic [31:0] ref_op(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, sq;
    logic [63:0] ua, ub, p;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (f)
      3'd0: begin p = ua * ub; return p[31:0]; end
      3'd1: begin sq = sa * sb; return sq[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFFFFFF;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return a;
        sq = sa / sb; return sq[31:0];
      end
      3'd5: begin
        if (b == 0) return 32'hFFFFFFFF;
        p = ua / ub; return p[31:0];
      end
      3'd6: begin
        if (b == 0) return a;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'd0;
        sq = sa % sb; return sq[31:0];
      end
      default: begin
        if (b == 0) return a;
        p = ua % ub; return p[31:0];
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the falling edge where done is seen
  task automatic run_op(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp, input bit intrude, input bit linger);
    int lat;
    int want;
    string tg;
    tg = tag_of(f, a, b);
    want = f[2] ? 33 : 1;
    req_valid = 1'b1; insn = mk_insn(f); src_a = a; src_b = b;
    @(posedge clk); #1;
    req_valid = 1'b0; src_a = ~a; src_b = a ^ 32'h5A5A0F0F;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      // R10: requests during busy must be ignored
      if (intrude && lat < 5) begin
        req_valid = 1'b1; insn = mk_insn(3'd0); src_a = 32'd3; src_b = 32'd3;
      end else begin
        req_valid = 1'b0;
      end
    end while (!done && lat < 100);
    req_valid = 1'b0;
    check(result == exp, tg, "result", result, exp);
    check(lat == want, f[2] ? "R9" : "R8", "latency", 32'(lat), 32'(want));
    check(!busy, f[2] ? "R9" : "R8", "busy at done", {31'd0, busy}, 32'd0);
    if (linger) begin
      @(negedge clk);
      check(!done && result == exp, "R12", "done pulse / result hold", {done, result[30:0]}, {1'b0, exp[30:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && result == 0, "R11", "reset state", {busy, done, result[29:0]}, 32'd0);

    // Table walk (R2 through R7)
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], (i == 8), 1'b1);

    // R1: foreign words must be ignored
    begin
      logic [31:0] held;
      held = result;
      req_valid = 1'b1; insn = {7'b0000000, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0110011};
      src_a = 32'd9; src_b = 32'd9;
      @(negedge clk);
      insn = {7'b0000001, 5'd2, 5'd1, 3'd4, 5'd3, 7'b0110111};
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(!busy && !done && result == held, "R1", "foreign word ignored", result, held);
    end

    // R10 + back-to-back: the next request rides the done cycle
    run_op(3'd5, 32'd1000, 32'd7, 32'd142, 1'b1, 1'b0);
    run_op(3'd0, 32'd12, 32'd12, 32'd144, 1'b0, 1'b0);
    run_op(3'd6, 32'd1000, 32'd7, 32'd6, 1'b0, 1'b0);
    run_op(3'd3, 32'h00010000, 32'h00010000, 32'h00000001, 1'b0, 1'b1);

    // Random and corner operands against the behavioural reference
    for (int k = 0; k < 80; k++) begin
      logic [2:0] f;
      logic [31:0] a, b;
      f = 3'($urandom_range(0, 7));
      a = ($urandom_range(0, 3) == 0) ? corners[$urandom_range(0, 4)] : $urandom;
      b = ($urandom_range(0, 3) == 0) ? corners[$urandom_range(0, 4)] : $urandom;
      run_op(f, a, b, ref_op(f, a, b), 1'b0, k[0]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule